// File: doc/BRIEF.md
# Doorbell Control/Status Register

This block is the host-side register window of a link to a front-end processor. The host writes a command word that sets or clears individual status flags. It reads back a status word. It writes a data-out word that either arms a transfer of up to 4095 bytes toward the host or, for one reserved value, forces a transfer error. A level interrupt request tells the host that a doorbell, a completion or an error needs attention. The interrupt uses a fixed vector.

The transfer engine on the far side reports through per-flag set and clear strobes. The block drives three one-cycle pulses back to that engine: a transfer request, a start-next-transfer request and a doorbell-service request. When the host and the engine act on the same flag in the same cycle, the host wins.

Top module: `doorbell_csr`

## Requirements
- R1: `stat_o` shows bit 15 = 1 at all times, bit 14 = `fe_dead_i`, bit 13 = to-front-end doorbell, bit 9 = to-host doorbell, bit 8 = to-front-end error, bit 6 = to-front-end done, bit 5 = to-host done, bit 4 = to-host error, bit 3 = interrupt enable, bits 2..0 = interrupt channel. All other bits read 0.
- R2: A command write with bit 4 set loads the enable and the channel from command bits 3..0. A command write without bit 4 leaves them unchanged.
- R3: Command bit 6 clears the to-front-end done and error flags. Command bit 5 clears the to-host done and error flags and makes `start_next_o` high for exactly the cycle after the write.
- R4: Command bit 9 clears the to-host doorbell. Command bit 12 clears the reload flag and command bit 11 sets it; when both are present, bit 11 wins. The reload flag is shown on `reload_o`.
- R5: Command bit 13 sets the to-front-end doorbell, clears the to-host doorbell and makes `db_svc_o` high for the cycle after the write.
- R6: In the cycle after any clock edge with no command write, `irq_o` equals the enable bit ANDed with the OR of the to-host doorbell, both done flags and both error flags, all taken as they stood before that edge.
- R7: In the cycle after a command write, `irq_o` is 0.
- R8: A data-out write of 16'h02F5 sets the to-host error and clears the to-host doorbell, the indirect flag (`ind_o`) and the to-front-end doorbell. It leaves `xfer_req_o` low and the byte count and interrupt bit unchanged.
- R9: Any other data-out write latches bit 12 into `xfer_ie_o` and bits 11..0 into `xfer_cnt_o`, and makes `xfer_req_o` high for the cycle after the write.
- R10: `vec_o` is constant 8'h6A.
- R11: Engine strobe bit order is 0 to-host error, 1 to-host done, 2 to-front-end done, 3 to-front-end error, 4 to-host doorbell, 5 to-front-end doorbell, 6 indirect. A host action on a flag overrides both engine strobes for that flag. An engine set overrides an engine clear.
- R12: While `rst_ni` is low, all flags, enable, channel, reload, count and pulses are 0, so `stat_o` = 16'h8000 | (`fe_dead_i` << 14) and `irq_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe |
| cmd_i | input | 16 | Command word |
| dout_we_i | input | 1 | Data-out write strobe |
| dout_i | input | 16 | Data-out word |
| fe_dead_i | input | 1 | Front-end dead indication |
| eng_set_i | input | 7 | Engine per-flag set strobes |
| eng_clr_i | input | 7 | Engine per-flag clear strobes |
| stat_o | output | 16 | Status word |
| irq_o | output | 1 | Level interrupt request |
| vec_o | output | 8 | Interrupt vector |
| xfer_req_o | output | 1 | Transfer request pulse |
| start_next_o | output | 1 | Start-next-transfer pulse |
| db_svc_o | output | 1 | Doorbell service pulse |
| xfer_cnt_o | output | 12 | Latched byte count |
| xfer_ie_o | output | 1 | Interrupt-after-transfer bit |
| reload_o | output | 1 | Reload flag |
| ind_o | output | 1 | Indirect-pending flag |

## Verification
The embedded properties check the following on every cycle:
- The interrupt drop after a command write, and the one-cycle-lagged interrupt equation otherwise.
- The doorbell ring effect.
- The reserved-value error path and the ordinary transfer request.
- The hold of enable and channel when bit 4 is absent.
- Host priority per flag.

Only the bench's scenarios can show the rest:
- The exact status bit layout across many flag patterns.
- Combined command bits acting together.
- Reload set-over-clear.
- Engine set-over-clear.
- The full sweep of data-out values next to the reserved one.

// File: rtl/dbcsr_pkg.sv
package dbcsr_pkg;
  localparam int DW     = 16;
  localparam int NFLAG  = 7;
  localparam int CNT_W  = 12;
  localparam int CH_W   = 3;
  localparam int VEC_W  = 8;

  // flag index
  localparam int F_HERR  = 0;
  localparam int F_HDONE = 1;
  localparam int F_FDONE = 2;
  localparam int F_FERR  = 3;
  localparam int F_HDB   = 4;
  localparam int F_FDB   = 5;
  localparam int F_IND   = 6;

  // command bits
  localparam int C_PIE_LD = 4;
  localparam int C_CLR_H  = 5;
  localparam int C_CLR_F  = 6;
  localparam int C_CLR_HDB = 9;
  localparam int C_RL_SET = 11;
  localparam int C_RL_CLR = 12;
  localparam int C_RING   = 13;

  // data-out fields
  localparam int D_IE     = 12;
  localparam logic [DW-1:0] DOUT_RSV = 16'h02F5;
  localparam logic [VEC_W-1:0] IRQ_VEC = 8'h6A;
endpackage

// File: rtl/dbcsr_decode.sv
module dbcsr_decode
  import dbcsr_pkg::*;
(
  input  logic             cmd_we_i,
  input  logic [DW-1:0]    cmd_i,
  input  logic             dout_we_i,
  input  logic [DW-1:0]    dout_i,
  output logic [NFLAG-1:0] host_set_o,
  output logic [NFLAG-1:0] host_clr_o,
  output logic             pie_ld_o,
  output logic             rl_set_o,
  output logic             rl_clr_o,
  output logic             start_next_o,
  output logic             ring_o,
  output logic             xfer_go_o
);
  logic rsv;
  assign rsv = dout_we_i && (dout_i == DOUT_RSV);

  always_comb begin
    host_set_o = '0;
    host_clr_o = '0;
    if (cmd_we_i) begin
      if (cmd_i[C_CLR_F]) begin
        host_clr_o[F_FDONE] = 1'b1;
        host_clr_o[F_FERR]  = 1'b1;
      end
      if (cmd_i[C_CLR_H]) begin
        host_clr_o[F_HDONE] = 1'b1;
        host_clr_o[F_HERR]  = 1'b1;
      end
      if (cmd_i[C_CLR_HDB]) host_clr_o[F_HDB] = 1'b1;
      if (cmd_i[C_RING]) begin
        host_set_o[F_FDB] = 1'b1;
        host_clr_o[F_HDB] = 1'b1;
      end
    end
    if (rsv) begin
      host_set_o[F_HERR] = 1'b1;
      host_clr_o[F_HDB]  = 1'b1;
      host_clr_o[F_IND]  = 1'b1;
      host_clr_o[F_FDB]  = 1'b1;
    end
  end

  assign pie_ld_o     = cmd_we_i && cmd_i[C_PIE_LD];
  assign rl_set_o     = cmd_we_i && cmd_i[C_RL_SET];
  assign rl_clr_o     = cmd_we_i && cmd_i[C_RL_CLR];
  assign start_next_o = cmd_we_i && cmd_i[C_CLR_H];
  assign ring_o       = cmd_we_i && cmd_i[C_RING];
  assign xfer_go_o    = dout_we_i && !rsv;
endmodule

// File: rtl/dbcsr_flags.sv
module dbcsr_flags
  import dbcsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NFLAG-1:0] host_set_i,
  input  logic [NFLAG-1:0] host_clr_i,
  input  logic [NFLAG-1:0] eng_set_i,
  input  logic [NFLAG-1:0] eng_clr_i,
  output logic [NFLAG-1:0] flags_o
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_flag
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)            q <= 1'b0;
      else if (host_set_i[i]) q <= 1'b1;
      else if (host_clr_i[i]) q <= 1'b0;
      else if (eng_set_i[i])  q <= 1'b1;
      else if (eng_clr_i[i])  q <= 1'b0;
    end
    assign flags_o[i] = q;

    // host clear beats any engine set
    p_host_wins_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_clr_i[i] && !host_set_i[i]) |=> !flags_o[i]);
  end
endmodule

// File: rtl/dbcsr_irq.sv
module dbcsr_irq
  import dbcsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic             en_i,
  input  logic [NFLAG-1:0] flags_i,
  output logic             irq_o
);
  logic any_src;
  assign any_src = flags_i[F_HERR] | flags_i[F_HDONE] | flags_i[F_FDONE]
                 | flags_i[F_FERR] | flags_i[F_HDB];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       irq_o <= 1'b0;
    else if (cmd_we_i) irq_o <= 1'b0;
    else               irq_o <= en_i & any_src;
  end

  p_cmd_drop_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_we_i |=> !irq_o);

  p_irq_track_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cmd_we_i |=> (irq_o == ($past(en_i) && $past(any_src))));
endmodule

// File: rtl/doorbell_csr.sv
module doorbell_csr
  import dbcsr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cmd_we_i,
  input  logic [15:0]      cmd_i,
  input  logic             dout_we_i,
  input  logic [15:0]      dout_i,
  input  logic             fe_dead_i,
  input  logic [6:0]       eng_set_i,
  input  logic [6:0]       eng_clr_i,
  output logic [15:0]      stat_o,
  output logic             irq_o,
  output logic [7:0]       vec_o,
  output logic             xfer_req_o,
  output logic             start_next_o,
  output logic             db_svc_o,
  output logic [11:0]      xfer_cnt_o,
  output logic             xfer_ie_o,
  output logic             reload_o,
  output logic             ind_o
);
  logic [NFLAG-1:0] host_set, host_clr, flags;
  logic pie_ld, rl_set, rl_clr, start_nx, ring, xfer_go;
  logic en_q, rl_q, ie_q, xreq_q, snx_q, dbs_q;
  logic [CH_W-1:0]  ch_q;
  logic [CNT_W-1:0] cnt_q;

  dbcsr_decode u_dec (
    .cmd_we_i, .cmd_i, .dout_we_i, .dout_i,
    .host_set_o(host_set), .host_clr_o(host_clr), .pie_ld_o(pie_ld),
    .rl_set_o(rl_set), .rl_clr_o(rl_clr), .start_next_o(start_nx),
    .ring_o(ring), .xfer_go_o(xfer_go)
  );

  dbcsr_flags u_flags (
    .clk_i, .rst_ni, .host_set_i(host_set), .host_clr_i(host_clr),
    .eng_set_i, .eng_clr_i, .flags_o(flags)
  );

  dbcsr_irq u_irq (
    .clk_i, .rst_ni, .cmd_we_i, .en_i(en_q), .flags_i(flags), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q <= 1'b0; ch_q <= '0; rl_q <= 1'b0;
      ie_q <= 1'b0; cnt_q <= '0;
      xreq_q <= 1'b0; snx_q <= 1'b0; dbs_q <= 1'b0;
    end else begin
      if (pie_ld) {en_q, ch_q} <= cmd_i[CH_W:0];
      if (rl_set)      rl_q <= 1'b1;
      else if (rl_clr) rl_q <= 1'b0;
      if (xfer_go) begin
        ie_q  <= dout_i[D_IE];
        cnt_q <= dout_i[CNT_W-1:0];
      end
      xreq_q <= xfer_go;
      snx_q  <= start_nx;
      dbs_q  <= ring;
    end
  end

  always_comb begin
    stat_o          = '0;
    stat_o[15]      = 1'b1;
    stat_o[14]      = fe_dead_i;
    stat_o[13]      = flags[F_FDB];
    stat_o[9]       = flags[F_HDB];
    stat_o[8]       = flags[F_FERR];
    stat_o[6]       = flags[F_FDONE];
    stat_o[5]       = flags[F_HDONE];
    stat_o[4]       = flags[F_HERR];
    stat_o[3]       = en_q;
    stat_o[CH_W-1:0] = ch_q;
  end

  assign vec_o        = IRQ_VEC;
  assign xfer_req_o   = xreq_q;
  assign start_next_o = snx_q;
  assign db_svc_o     = dbs_q;
  assign xfer_cnt_o   = cnt_q;
  assign xfer_ie_o    = ie_q;
  assign reload_o     = rl_q;
  assign ind_o        = flags[F_IND];

  p_ring_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && cmd_i[C_RING]) |=> (stat_o[13] && !stat_o[9] && db_svc_o));

  p_reserved_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_we_i && dout_i == DOUT_RSV && !cmd_we_i) |=>
      (stat_o[4] && !ind_o && !xfer_req_o && $stable(xfer_cnt_o)));

  p_xfer_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dout_we_i && dout_i != DOUT_RSV) |=>
      (xfer_req_o && xfer_cnt_o == $past(dout_i[CNT_W-1:0])));

  p_pie_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_we_i && !cmd_i[C_PIE_LD]) |=> $stable(stat_o[3:0]));
endmodule

// File: tb/tb_doorbell_csr.sv
`timescale 1ns/1ps
module tb_doorbell_csr;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cmd_we_i = 1'b0, dout_we_i = 1'b0, fe_dead_i = 1'b0;
  logic [15:0] cmd_i = '0, dout_i = '0;
  logic [6:0]  eng_set_i = '0, eng_clr_i = '0;
  logic [15:0] stat_o;
  logic        irq_o, xfer_req_o, start_next_o, db_svc_o, xfer_ie_o, reload_o, ind_o;
  logic [7:0]  vec_o;
  logic [11:0] xfer_cnt_o;

  always #2.5 clk_i = ~clk_i;

  doorbell_csr dut (.*);

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  // bench model
  logic [6:0]  m_f = '0;
  logic        m_en = 1'b0, m_rl = 1'b0, m_ie = 1'b0;
  logic [2:0]  m_ch = '0;
  logic [11:0] m_cnt = '0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_stat(input logic [6:0] f, input logic en,
                                           input logic [2:0] ch, input logic dead);
    logic [15:0] s;
    s = 16'h8000;
    s[14] = dead; s[13] = f[5]; s[9] = f[4]; s[8] = f[3];
    s[6] = f[2]; s[5] = f[1]; s[4] = f[0]; s[3] = en; s[2:0] = ch;
    return s;
  endfunction

  // one clock cycle of stimulus with full checking
  task automatic op(input logic cw, input logic [15:0] c, input logic dw,
                    input logic [15:0] d, input logic [6:0] es, input logic [6:0] ec);
    logic [6:0] hs, hc, nf;
    logic exp_irq, rsv;
    rsv = dw && (d == 16'h02F5);
    hs = '0; hc = '0;
    if (cw) begin
      if (c[6])  begin hc[2] = 1; hc[3] = 1; end       // R3
      if (c[5])  begin hc[1] = 1; hc[0] = 1; end       // R3
      if (c[9])  hc[4] = 1;                            // R4
      if (c[13]) begin hs[5] = 1; hc[4] = 1; end       // R5
    end
    if (rsv) begin hs[0] = 1; hc[4] = 1; hc[6] = 1; hc[5] = 1; end  // R8
    for (int i = 0; i < 7; i++)
      nf[i] = hs[i] ? 1'b1 : hc[i] ? 1'b0 : es[i] ? 1'b1 : ec[i] ? 1'b0 : m_f[i];
    exp_irq = cw ? 1'b0 : (m_en & |m_f[4:0]);
    m_f = nf;
    if (cw && c[4]) {m_en, m_ch} = c[3:0];
    if (cw && c[12]) m_rl = 1'b0;
    if (cw && c[11]) m_rl = 1'b1;
    if (dw && !rsv) begin m_ie = d[12]; m_cnt = d[11:0]; end
    @(negedge clk_i);
    cmd_we_i = cw; cmd_i = c; dout_we_i = dw; dout_i = d;
    eng_set_i = es; eng_clr_i = ec;
    @(negedge clk_i);
    chk("R1 stat", stat_o, exp_stat(m_f, m_en, m_ch, fe_dead_i));
    chk(cw ? "R7 irq" : "R6 irq", irq_o, exp_irq);
    chk("R11 ind", ind_o, m_f[6]);
    chk("R4 reload", reload_o, m_rl);
    chk("R3 start_next", start_next_o, cw & c[5]);
    chk("R5 db_svc", db_svc_o, cw & c[13]);
    chk(rsv ? "R8 xfer_req" : "R9 xfer_req", xfer_req_o, dw & !rsv);
    chk("R9 cnt", xfer_cnt_o, m_cnt);
    chk("R9 ie", xfer_ie_o, m_ie);
    cmd_we_i = 0; dout_we_i = 0; eng_set_i = '0; eng_clr_i = '0;
  endtask

  initial begin
    #(2.5 * 2 * 150000);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    fe_dead_i = 1'b1;
    repeat (3) @(negedge clk_i);
    chk("R12 reset stat", stat_o, 16'hC000);
    chk("R12 reset irq", irq_o, 0);
    chk("R12 reset pulses", {xfer_req_o, start_next_o, db_svc_o, reload_o, ind_o}, 0);
    chk("R10 vector", vec_o, 8'h6A);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R12 after release", stat_o, 16'hC000);

    // R2 R3 R4 R5 R6 R7 R11: every combination of active command bits over several flag patterns
    for (int p = 0; p < 3; p++) begin
      logic [6:0] pat;
      pat = (p == 0) ? 7'h7F : (p == 1) ? 7'h00 : 7'h55;
      fe_dead_i = p[0];
      for (int k = 0; k < 128; k++) begin
        logic [15:0] c;
        c = '0;
        c[4] = k[0]; c[5] = k[1]; c[6] = k[2]; c[9] = k[3];
        c[11] = k[4]; c[12] = k[5]; c[13] = k[6];
        c[3:0] = 4'(k * 5 + p);
        op(0, '0, 0, '0, pat, ~pat);                          // preset
        op(1, c, 0, '0, 7'(k * 3), 7'(k * 5));                // command with engine contention
        op(0, '0, 0, '0, '0, '0);                             // R6 idle follow-up
      end
    end

    // R11 dedicated contention cases
    op(1, 16'h0018, 0, '0, '0, '0);                           // enable on, channel 0
    op(1, 16'h0020, 0, '0, 7'h03, '0);                        // R11 host clear beats engine set
    op(1, 16'h2000, 0, '0, '0, 7'h30);                        // R11 ring beats engine clear
    op(0, '0, 0, '0, 7'h7F, 7'h7F);                           // R11 engine set beats clear
    op(1, 16'h0200, 0, '0, 7'h10, '0);                        // R4 clear host doorbell vs engine

    // R8 R9: data-out sweep with reserved value interleaved
    for (int i = 0; i < 8192; i++) begin
      if (i % 256 == 0) begin
        op(0, '0, 0, '0, 7'h70, '0);                          // arm doorbells and indirect
        op(0, '0, 1, 16'h02F5, '0, '0);                       // R8 reserved
      end
      op(0, '0, 1, {i[2:0], i[12:0]}, '0, '0);                // R9
    end
    op(0, '0, 1, 16'h02F4, '0, '0);                           // R9 neighbour
    op(0, '0, 1, 16'h02F6, '0, '0);                           // R9 neighbour
    op(0, '0, 1, 16'h12F5, '0, '0);                           // R9 one bit off
    op(0, '0, 0, '0, '0, '0);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule